// File: doc/BRIEF.md
# Command and Completion Ring Manager

This block is the hardware end of two host-memory rings that serve one disk channel. Software posts commands into a 32-slot command ring and moves a producer index forward. The block compares that index with its own consumer index. While the engine is switched on and work is waiting, it fetches the next command entry through a simple memory request port. It passes the command word to the channel executor and waits for the executor to finish. It then writes an 8-byte completion record into a 32-slot completion ring and raises a one-cycle done pulse toward the interrupt logic.

Software drives the block through eight 32-bit registers. Ring indices sit inside address-aligned words, so one register carries both the low base bits and the index. The engine is switched on and off with separate write-one bits. A switch-off request lets the entry in flight finish first. A configuration word can make the engine stop by itself after a command that reports a device error.

Top module: `rmgr_ring_mgr`

## Requirements
- R1: After reset the engine is off, every ring index reads zero and no memory request is raised.
- R2: Register offsets are 0 config, 1 command base high, 2 command producer, 3 command consumer, 4 completion base high, 5 completion producer, 6 completion consumer, 7 engine. In offset 2, bits [31:10] hold the low base and bits [9:5] hold the producer index. Bits [4:0] read as zero. The fetch address of slot i is {base high, base[31:10], i, 5'b0}.
- R3: A command is fetched only while the engine is on and the producer index differs from the consumer index. Each fetched entry advances the consumer index (offset 3, bits [9:5], base bits as in offset 2) by one.
- R4: A write to offset 7 with bit 0 set switches the engine on. A write with bit 1 set switches it off, and bit 1 wins when both are set. Reading offset 7 returns bit 0 = on and bit 1 = busy with an entry.
- R5: A switch-off that arrives during an entry lets that entry post its completion. The on bit then clears and nothing more is fetched.
- R6: A completion record carries the tag (command word bits [15:1]) in bits [15:0] and the engine status in bits [23:16]. The engine status has bit 0 = device error, taken from device status bit 0. Bits [31:24] hold the device status and bits [63:32] a free-running cycle timestamp. The record goes to {completion base high, base[31:8], index, 3'b0}. Offsets 5 and 6 keep the index in bits [7:3].
- R7: No completion is written while the completion producer index plus one equals the software consumer index (mod 32). Posting resumes once software acknowledges.
- R8: Each posted completion advances the completion producer index and gives exactly one single-cycle done pulse.
- R9: The config word (offset 0) reads back as written. With its bit 0 set, a completion whose device status has bit 0 set switches the engine off after posting.
- R10: A fetch request stays raised until it is granted.
- R11: All indices wrap from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a completion write |
| mem_addr | output | 64 | Entry address |
| mem_wdata | output | 64 | Completion record |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Fetched command word valid |
| mem_rdata | input | 32 | Fetched command word |
| cmd_start | output | 1 | One-cycle start toward the executor |
| cmd_word | output | 32 | Current command word |
| cmd_done | input | 1 | Executor finished |
| cmd_dev_status | input | 8 | Device status from the executor |
| done_pulse | output | 1 | Completion posted |

## Verification
The bench writes the producer index while the engine is off, which catches a design that fetches without checking the on bit. It lets the ring drain, which catches a design that keeps fetching on an empty ring. It fills the completion ring to one short of the acknowledged slot. A design that tests fullness wrongly would write over an unacknowledged record, or would stay stuck after the acknowledgement. It sends a switch-off while an entry is held in execution. A design that stops at once would lose that completion, and one that ignores the request would fetch the next entry. It also runs the indices across the 31-to-0 wrap, and it withholds the grant to check that a fetch request is held.

// File: rtl/rmgr_pkg.sv
package rmgr_pkg;
  localparam int IDX_W      = 5;
  localparam int CMD_SH     = 5;
  localparam int CPL_SH     = 3;
  localparam int WORD_W     = 32;
  localparam int CMD_BASE_W = WORD_W - IDX_W - CMD_SH;
  localparam int CPL_BASE_W = WORD_W - IDX_W - CPL_SH;
  localparam int ADDR_W     = 2 * WORD_W;

  localparam logic [2:0] RA_CFG      = 3'd0;
  localparam logic [2:0] RA_CMD_HI   = 3'd1;
  localparam logic [2:0] RA_CMD_PROD = 3'd2;
  localparam logic [2:0] RA_CMD_CONS = 3'd3;
  localparam logic [2:0] RA_CPL_HI   = 3'd4;
  localparam logic [2:0] RA_CPL_PROD = 3'd5;
  localparam logic [2:0] RA_CPL_CONS = 3'd6;
  localparam logic [2:0] RA_ENGINE   = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT_RD, ST_EXEC, ST_POST
  } eng_state_e;

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  function automatic logic ring_full(input logic [IDX_W-1:0] prod,
                                     input logic [IDX_W-1:0] cons);
    return idx_next(prod) == cons;
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_slot_addr(
      input logic [WORD_W-1:0] hi, input logic [CMD_BASE_W-1:0] lo,
      input logic [IDX_W-1:0] i);
    return {hi, lo, i, {CMD_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] cpl_slot_addr(
      input logic [WORD_W-1:0] hi, input logic [CPL_BASE_W-1:0] lo,
      input logic [IDX_W-1:0] i);
    return {hi, lo, i, {CPL_SH{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] cpl_pack(
      input logic [15:0] tag, input logic [7:0] est,
      input logic [7:0] dst, input logic [WORD_W-1:0] ts);
    return {ts, dst, est, tag};
  endfunction
endpackage

// File: rtl/rmgr_regs.sv
module rmgr_regs
  import rmgr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [2:0]            addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output logic                  halt_on_err,
  output logic [WORD_W-1:0]     cmd_hi,
  output logic [CMD_BASE_W-1:0] cmd_lo,
  output logic [IDX_W-1:0]      sw_prod,
  output logic [WORD_W-1:0]     cpl_hi,
  output logic [CPL_BASE_W-1:0] cpl_lo,
  output logic [IDX_W-1:0]      sw_cons,
  output logic                  en_req,
  output logic                  dis_req,
  input  logic [IDX_W-1:0]      hw_cons,
  input  logic [IDX_W-1:0]      hw_cpl,
  input  logic                  eng_on,
  input  logic                  eng_busy
);
  logic [WORD_W-1:0] cfg_q;
  logic              eng_wr;

  assign eng_wr      = wr && (addr == RA_ENGINE);
  assign dis_req     = eng_wr && wdata[1];
  assign en_req      = eng_wr && wdata[0] && !wdata[1];
  assign halt_on_err = cfg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cmd_hi  <= '0;
      cmd_lo  <= '0;
      sw_prod <= '0;
      cpl_hi  <= '0;
      cpl_lo  <= '0;
      sw_cons <= '0;
    end else if (wr) begin
      case (addr)
        RA_CFG:      cfg_q  <= wdata;
        RA_CMD_HI:   cmd_hi <= wdata;
        RA_CMD_PROD: begin
          cmd_lo  <= wdata[WORD_W-1 -: CMD_BASE_W];
          sw_prod <= wdata[CMD_SH +: IDX_W];
        end
        RA_CPL_HI:   cpl_hi <= wdata;
        RA_CPL_CONS: begin
          cpl_lo  <= wdata[WORD_W-1 -: CPL_BASE_W];
          sw_cons <= wdata[CPL_SH +: IDX_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_CFG:      rdata = cfg_q;
      RA_CMD_HI:   rdata = cmd_hi;
      RA_CMD_PROD: rdata = {cmd_lo, sw_prod, {CMD_SH{1'b0}}};
      RA_CMD_CONS: rdata = {cmd_lo, hw_cons, {CMD_SH{1'b0}}};
      RA_CPL_HI:   rdata = cpl_hi;
      RA_CPL_PROD: rdata = {cpl_lo, hw_cpl, {CPL_SH{1'b0}}};
      RA_CPL_CONS: rdata = {cpl_lo, sw_cons, {CPL_SH{1'b0}}};
      default:     rdata = {{(WORD_W-2){1'b0}}, eng_busy, eng_on};
    endcase
  end
endmodule

// File: rtl/rmgr_engine.sv
module rmgr_engine
  import rmgr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  halt_on_err,
  input  logic [WORD_W-1:0]     cmd_hi,
  input  logic [CMD_BASE_W-1:0] cmd_lo,
  input  logic [IDX_W-1:0]      sw_prod,
  input  logic [WORD_W-1:0]     cpl_hi,
  input  logic [CPL_BASE_W-1:0] cpl_lo,
  input  logic [IDX_W-1:0]      sw_cons,
  input  logic                  en_req,
  input  logic                  dis_req,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [ADDR_W-1:0]     mem_wdata,
  input  logic                  mem_gnt,
  input  logic                  mem_rvalid,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  cmd_start,
  output logic [WORD_W-1:0]     cmd_word,
  input  logic                  cmd_done,
  input  logic [7:0]            cmd_dev_status,
  output logic                  done_pulse,
  output logic [IDX_W-1:0]      hw_cons,
  output logic [IDX_W-1:0]      hw_cpl,
  output logic                  eng_on,
  output logic                  eng_busy
);
  eng_state_e        state;
  logic              dis_pend;
  logic [7:0]        dev_q;
  logic [WORD_W-1:0] ts;

  // named internal events, shared by the logic and the assertions
  logic work_waiting, launch, cpl_blocked, post_acc, stop_on_err;

  assign work_waiting = (sw_prod != hw_cons);
  assign launch       = (state == ST_IDLE) && eng_on && work_waiting &&
                        !dis_req && !dis_pend;
  assign cpl_blocked  = ring_full(hw_cpl, sw_cons);
  assign post_acc     = (state == ST_POST) && !cpl_blocked && mem_gnt;
  assign stop_on_err  = halt_on_err && dev_q[0];

  assign eng_busy  = (state != ST_IDLE);
  assign mem_we    = (state == ST_POST);
  assign mem_req   = (state == ST_FETCH) || ((state == ST_POST) && !cpl_blocked);
  assign mem_addr  = mem_we ? cpl_slot_addr(cpl_hi, cpl_lo, hw_cpl)
                            : cmd_slot_addr(cmd_hi, cmd_lo, hw_cons);
  assign mem_wdata = cpl_pack({1'b0, cmd_word[15:1]}, {7'b0, dev_q[0]}, dev_q, ts);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      eng_on     <= 1'b0;
      dis_pend   <= 1'b0;
      hw_cons    <= '0;
      hw_cpl     <= '0;
      cmd_word   <= '0;
      dev_q      <= '0;
      cmd_start  <= 1'b0;
      done_pulse <= 1'b0;
      ts         <= '0;
    end else begin
      ts         <= ts + 1'b1;
      cmd_start  <= 1'b0;
      done_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (dis_pend) begin
            eng_on   <= 1'b0;
            dis_pend <= 1'b0;
          end else if (launch) begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH:   if (mem_gnt) state <= ST_WAIT_RD;
        ST_WAIT_RD: if (mem_rvalid) begin
          cmd_word  <= mem_rdata;
          hw_cons   <= idx_next(hw_cons);
          cmd_start <= 1'b1;
          state     <= ST_EXEC;
        end
        ST_EXEC: if (cmd_done) begin
          dev_q <= cmd_dev_status;
          state <= ST_POST;
        end
        ST_POST: if (post_acc) begin
          hw_cpl     <= idx_next(hw_cpl);
          done_pulse <= 1'b1;
          state      <= ST_IDLE;
          if (dis_pend || stop_on_err) begin
            eng_on   <= 1'b0;
            dis_pend <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (en_req) begin
        eng_on   <= 1'b1;
        dis_pend <= 1'b0;
      end else if (dis_req) begin
        if (state == ST_IDLE) eng_on <= 1'b0;
        else                  dis_pend <= 1'b1;
      end
    end
  end

  // fetches only happen with the engine on
  assert_fetch_needs_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> eng_on);

  // consumer moves by exactly one, and only over a non-empty ring
  assert_cons_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_cons != $past(hw_cons)) |->
      ($past(sw_prod != hw_cons) && (hw_cons == $past(hw_cons) + 1'b1)));

  // the on bit only falls between entries
  assert_drain_before_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_on) |-> ($past(state == ST_IDLE) || $past(post_acc)));

  // no completion over an unacknowledged slot
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_cpl != $past(hw_cpl)) |-> !$past(ring_full(hw_cpl, sw_cons)));

  // done pulse follows each producer step and lasts one cycle
  assert_done_tracks_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (hw_cpl == $past(hw_cpl) + 1'b1));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // fetch request held until granted
  assert_fetch_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_gnt) |=> (mem_req && !mem_we && $stable(mem_addr)));
endmodule

// File: rtl/rmgr_ring_mgr.sv
module rmgr_ring_mgr
  import rmgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cmd_start,
  output logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_dev_status,
  output logic              done_pulse
);
  logic                  halt_on_err, en_req, dis_req, eng_on, eng_busy;
  logic [WORD_W-1:0]     cmd_hi, cpl_hi;
  logic [CMD_BASE_W-1:0] cmd_lo;
  logic [CPL_BASE_W-1:0] cpl_lo;
  logic [IDX_W-1:0]      sw_prod, sw_cons, hw_cons, hw_cpl;

  rmgr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .halt_on_err(halt_on_err), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .sw_prod(sw_prod), .cpl_hi(cpl_hi), .cpl_lo(cpl_lo), .sw_cons(sw_cons),
    .en_req(en_req), .dis_req(dis_req), .hw_cons(hw_cons), .hw_cpl(hw_cpl),
    .eng_on(eng_on), .eng_busy(eng_busy)
  );

  rmgr_engine u_engine (
    .clk(clk), .rst_n(rst_n), .halt_on_err(halt_on_err), .cmd_hi(cmd_hi),
    .cmd_lo(cmd_lo), .sw_prod(sw_prod), .cpl_hi(cpl_hi), .cpl_lo(cpl_lo),
    .sw_cons(sw_cons), .en_req(en_req), .dis_req(dis_req), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_start(cmd_start),
    .cmd_word(cmd_word), .cmd_done(cmd_done), .cmd_dev_status(cmd_dev_status),
    .done_pulse(done_pulse), .hw_cons(hw_cons), .hw_cpl(hw_cpl),
    .eng_on(eng_on), .eng_busy(eng_busy)
  );
endmodule

// File: tb/rmgr_ring_mgr_tb_top.sv
module rmgr_ring_mgr_tb_top;
  localparam logic [2:0] A_CFG = 3'd0, A_CHI = 3'd1, A_CPROD = 3'd2, A_CCONS = 3'd3,
                         A_PHI = 3'd4, A_PPROD = 3'd5, A_PCONS = 3'd6, A_ENG = 3'd7;
  localparam logic [31:0] CBASE = 32'hABCD_0400, PBASE = 32'h5555_5500;
  localparam logic [31:0] CHI = 32'h0000_0012, PHI = 32'h0000_0034;

  logic        clk = 1'b0;
  logic        rst_n, reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_rdata, cmd_word;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, cmd_start, cmd_done, done_pulse;
  logic [63:0] mem_addr, mem_wdata;
  logic [7:0]  cmd_dev_status;

  always #5 clk = ~clk;

  rmgr_ring_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_start(cmd_start),
    .cmd_word(cmd_word), .cmd_done(cmd_done), .cmd_dev_status(cmd_dev_status),
    .done_pulse(done_pulse)
  );

  int n_chk = 0, n_bad = 0, fetch_n = 0, cpl_n = 0, done_n = 0;
  logic [63:0] fetch_a [0:63];
  logic [63:0] cpl_a   [0:63];
  logic [63:0] cpl_d   [0:63];
  logic        gnt_block = 1'b0, exec_hold = 1'b0, rd_due = 1'b0;
  logic [31:0] rd_word = '0;
  logic [7:0]  dev_stat = 8'h50;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: grant one cycle, read data one cycle later
  initial begin
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rd_due) begin mem_rvalid = 1'b1; mem_rdata = rd_word; rd_due = 1'b0; end
      if (mem_gnt) mem_gnt = 1'b0;
      else if (rst_n && mem_req && !gnt_block) begin
        mem_gnt = 1'b1;
        if (mem_we) begin
          if (cpl_n < 64) begin cpl_a[cpl_n] = mem_addr; cpl_d[cpl_n] = mem_wdata; end
          cpl_n++;
        end else begin
          if (fetch_n < 64) fetch_a[fetch_n] = mem_addr;
          fetch_n++;
          rd_word = {16'h0, 10'h0, mem_addr[9:5], 1'b1};
          rd_due  = 1'b1;
        end
      end
    end
  end

  // executor model
  initial begin
    cmd_done = 1'b0; cmd_dev_status = '0;
    forever begin
      @(negedge clk);
      if (cmd_start) begin
        while (exec_hold) @(negedge clk);
        @(negedge clk);
        cmd_done = 1'b1; cmd_dev_status = dev_stat;
        @(negedge clk);
        cmd_done = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && done_pulse) done_n++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cpl(input int n, input string req);
    int t = 0;
    while (cpl_n < n && t < 400) begin @(negedge clk); t++; end
    chk(req, 64'(cpl_n), 64'(n));
    idle(3);
  endtask

  function automatic logic [63:0] exp_fetch(input int i);
    return {CHI, CBASE | (32'(i % 32) << 5)};
  endfunction
  function automatic logic [63:0] exp_cpl(input int i);
    return {PHI, PBASE | (32'(i % 32) << 3)};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(A_ENG, v);   chk("R1 engine after reset", 64'(v), 64'h0);
    rd(A_CCONS, v); chk("R1 cmd consumer after reset", 64'(v), 64'h0);
    rd(A_PPROD, v); chk("R1 cpl producer after reset", 64'(v), 64'h0);
    chk("R1 no request after reset", 64'(mem_req), 64'h0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wr(A_CHI, CHI); wr(A_PHI, PHI); wr(A_PCONS, PBASE);
    wr(A_CPROD, CBASE | 32'h5F);          // index 2, low bits ignored
    rd(A_CPROD, v); chk("R2 producer layout", 64'(v), 64'(CBASE | 32'h40));
    idle(10);
    chk("R3 no fetch while off", 64'(fetch_n), 64'h0);
    wr(A_ENG, 32'h1);
    wait_cpl(2, "R3 two entries processed");
    chk("R2 fetch address slot 0", fetch_a[0], exp_fetch(0));
    chk("R2 fetch address slot 1", fetch_a[1], exp_fetch(1));
    chk("R6 cpl address slot 1", cpl_a[1], exp_cpl(1));
    chk("R6 cpl fields slot 1", 64'(cpl_d[1][31:0]), 64'({8'h50, 8'h00, 16'h0001}));
    chk("R6 timestamp advances", 64'(cpl_d[1][63:32] > cpl_d[0][63:32]), 64'h1);
    rd(A_CCONS, v); chk("R3 consumer index", 64'(v), 64'(CBASE | 32'h40));
    rd(A_PPROD, v); chk("R8 cpl producer index", 64'(v), 64'(PBASE | 32'h10));
    rd(A_ENG, v);   chk("R4 engine reads on, idle", 64'(v), 64'h1);
    chk("R8 done pulses", 64'(done_n), 64'h2);
    idle(20);
    chk("R3 empty ring not fetched", 64'(fetch_n), 64'h2);
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(A_PCONS, PBASE | (32'd3 << 3));    // producer 2 + 1 == 3: full
    wr(A_CPROD, CBASE | (32'd3 << 5));
    idle(30);
    chk("R7 no write while full", 64'(cpl_n), 64'h2);
    rd(A_CCONS, v); chk("R7 entry fetched while full", 64'(v), 64'(CBASE | (32'd3 << 5)));
    rd(A_PPROD, v); chk("R7 producer held", 64'(v), 64'(PBASE | (32'd2 << 3)));
    rd(A_ENG, v);   chk("R4 busy while stalled", 64'(v), 64'h3);
    wr(A_PCONS, PBASE);
    wait_cpl(3, "R7 resumes after ack");
    chk("R7 cpl address slot 2", cpl_a[2], exp_cpl(2));
  endtask

  task automatic t_grant_hold;
    logic [63:0] a1;
    gnt_block = 1'b1;
    wr(A_CPROD, CBASE | (32'd4 << 5));
    idle(6);
    a1 = mem_addr;
    chk("R10 request raised", 64'({mem_req, mem_we}), 64'h2);
    chk("R10 fetch address", a1, exp_fetch(3));
    idle(6);
    chk("R10 request still held", 64'({mem_req, mem_we}), 64'h2);
    chk("R10 address stable", mem_addr, a1);
    gnt_block = 1'b0;
    wait_cpl(4, "R10 completes after grant");
  endtask

  task automatic t_disable;
    logic [31:0] v;
    int t = 0;
    exec_hold = 1'b1;
    wr(A_CPROD, CBASE | (32'd6 << 5));
    while (fetch_n < 5 && t < 100) begin @(negedge clk); t++; end
    idle(4);
    wr(A_ENG, 32'h2);
    rd(A_ENG, v); chk("R5 stays on during entry", 64'(v), 64'h3);
    exec_hold = 1'b0;
    wait_cpl(5, "R5 entry in flight completes");
    rd(A_ENG, v);   chk("R5 off after drain", 64'(v), 64'h0);
    rd(A_CCONS, v); chk("R5 one entry consumed", 64'(v), 64'(CBASE | (32'd5 << 5)));
    idle(20);
    chk("R5 no fetch after off", 64'(fetch_n), 64'h5);
    wr(A_ENG, 32'h3);
    rd(A_ENG, v); chk("R4 off wins over on", 64'(v), 64'h0);
    wr(A_ENG, 32'h1);
    wait_cpl(6, "R4 re-enable resumes");
  endtask

  task automatic t_halt;
    logic [31:0] v;
    wr(A_CFG, 32'h1);
    rd(A_CFG, v); chk("R9 config readback", 64'(v), 64'h1);
    dev_stat = 8'h51;
    wr(A_CPROD, CBASE | (32'd7 << 5));
    wait_cpl(7, "R9 error entry posted");
    rd(A_ENG, v); chk("R9 engine stops on error", 64'(v), 64'h0);
    chk("R6 error status fields", 64'(cpl_d[6][31:0]), 64'({8'h51, 8'h01, 16'h0006}));
    wr(A_CFG, 32'h0);
    dev_stat = 8'h50;
    wr(A_ENG, 32'h1);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    for (int k = 7; k < 40; k++) begin
      wr(A_PCONS, PBASE | (32'(k % 32) << 3));
      wr(A_CPROD, CBASE | (32'((k + 1) % 32) << 5));
      wait_cpl(k + 1, "R11 entry across wrap");
    end
    rd(A_CCONS, v); chk("R11 consumer wrapped", 64'(v), 64'(CBASE | (32'd8 << 5)));
    rd(A_PPROD, v); chk("R11 cpl producer wrapped", 64'(v), 64'(PBASE | (32'd8 << 3)));
    chk("R11 fetch after wrap", fetch_a[32], exp_fetch(0));
    chk("R11 cpl address after wrap", cpl_a[39], exp_cpl(39));
    chk("R6 tag after wrap", 64'(cpl_d[39][15:0]), 64'h7);
    chk("R8 one pulse per completion", 64'(done_n), 64'(cpl_n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_full();
    t_grant_hold();
    t_disable();
    t_halt();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule